// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is a single 16-bit down-counting channel for an interval timer built from several identical channels. Software reaches it through a byte-wide interface. A control port that all channels share carries a control word. The word either takes a snapshot of the running count or picks the channel's counting mode. A separate data port loads the starting count and reads the count back, always as two bytes, low byte first.

The counter steps down once on each clock cycle where the tick enable strobe is high, so it runs at the timer input rate. The channel has three behaviours:

- **One-shot mode:** the channel counts to terminal count once, drives its output level high, pulses its interrupt, and then stays stopped until it is reloaded.
- **Rate-generator mode and periodic mode:** these two modes behave the same way. The channel terminates at one instead of zero, so the effective period is the loaded count minus one. It reloads that period by itself and pulses the interrupt once per period.

Writing the low byte of a new count stops the channel. Writing the high byte restarts it.

Top module: `ptmr_channel`

## Requirements
- R1: The data port keeps a write pointer. The first byte written after reset is the low byte of the count, and the pointer then alternates between the high byte and the low byte on every write.
- R2: Writing the low byte stops any countdown in progress and drives `timerOut` low. While the channel is stopped, a live read returns 0 in both bytes.
- R3: Writing the high byte in one-shot mode starts the countdown with a period equal to the loaded count. The interrupt pulse appears after that many ticks.
- R4: In rate-generator mode and periodic mode, the period is the loaded count minus one. The channel reloads the period at each terminal count and pulses `irqPulse` once per period. `timerOut` stays low in these modes.
- R5: In one-shot mode, terminal count raises `timerOut` and pulses `irqPulse` for exactly one cycle. Both become visible after the same clock edge. The channel then stops: live reads return 0 and further ticks raise no interrupt.
- R6: A loaded count of 0 in any mode does not start the channel. A loaded count of 1 in rate-generator or periodic mode also does not start it.
- R7: A latch command captures the live count only when no latched value is waiting to be read. Any further latch command is ignored until the high byte of the latched value has been read. That read releases the latch.
- R8: A latch command that captures a count also resets the read pointer to the low byte. Reads of a latched value return the low byte first, then the high byte.
- R9: A read without a latch returns a byte of the live count, alternating low byte and high byte.
  - In rate-generator and periodic modes the live count is the remaining ticks plus one.
  - In one-shot mode the live count is the remaining ticks.
- R10: The control word uses these fields:

  | Bits | Field | Values |
  |------|-------|--------|
  | [7:6] | channel select | 3 means read-back and is ignored |
  | [5:4] | access | 0 = latch command, 3 = low byte then high byte |
  | [3:1] | mode | 0 = one-shot, 2 = rate generator, 3 = periodic |
  | [0] | BCD | must be 0 |

  A word is ignored if it selects another channel, uses select value 3, uses access 1 or 2, sets BCD, or names any other mode.
- R11: The count changes only on cycles where `tickEn` is high. While `tickEn` stays low, no interrupt occurs and the live count holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count enable strobe at the timer input rate |
| ctrlWe | input | 1 | Control word write strobe (shared control port) |
| ctrlData | input | 8 | Control word |
| dataWe | input | 1 | Count byte write strobe |
| dataWdata | input | BYTE_W | Count byte to write |
| dataRe | input | 1 | Count byte read strobe; advances the read pointer |
| dataRdata | output | BYTE_W | Byte selected by the read pointer (live or latched) |
| timerOut | output | 1 | Output level; rises at one-shot terminal count |
| irqPulse | output | 1 | Single-cycle interrupt pulse at every terminal count |

## Verification
A wrong internal state appears at the ports within one cycle in the following cases:

- **Byte pointer out of step:** it splits a count across the wrong bytes, so the next readback returns a swapped or mixed value.
- **Lost mode register:** it changes the live count by exactly one (plus one in the periodic modes, none in one-shot), so the first readback after loading shows it.
- **Countdown off by a tick:** the interrupt arrives one cycle early or late compared with the tick count, which the interrupt counting exposes at the first terminal count.
- **Latch that never releases:** it freezes readback across later ticks, so the read after the high byte shows a stale value instead of the live count.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

  // Counting behaviours; encodings match the control word mode field.
  typedef enum logic [2:0] {
    MODE_ONESHOT = 3'd0,
    MODE_RATE    = 3'd2,
    MODE_WAVE    = 3'd3
  } chanMode_t;

  // Control word layout, most significant field first.
  typedef struct packed {
    logic [1:0] sel;
    logic [1:0] access;
    logic [2:0] mode;
    logic       bcd;
  } ctrlWord_t;

  localparam logic [1:0] ACC_LATCH    = 2'd0;
  localparam logic [1:0] ACC_LOHI     = 2'd3;
  localparam logic [1:0] SEL_READBACK = 2'd3;

  // Strobes and levels handed from control to datapath.
  typedef struct packed {
    logic wrLow;        // data byte write targets the low byte
    logic wrHigh;       // data byte write targets the high byte
    logic capture;      // take a snapshot of the live count
    logic periodic;     // rate or wave mode is active
    logic showLatched;  // read path shows the snapshot
    logic showHigh;     // read path shows the high byte
  } dpStrobe_t;

  function automatic logic modeSupported(input logic [2:0] m);
    case (m)
      MODE_ONESHOT, MODE_RATE, MODE_WAVE: modeSupported = 1'b1;
      default:                            modeSupported = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ptmr_ctrl.sv
module ptmr_ctrl
  import ptmr_pkg::*;
#(
  parameter int CHAN_ID = 0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWe,
  input  logic [7:0] ctrlData,
  input  logic       dataWe,
  input  logic       dataRe,
  output dpStrobe_t  dpStb
);

  localparam logic [1:0] MY_SEL = CHAN_ID[1:0];

  ctrlWord_t word;
  logic      selHit;
  logic      latchCmd;
  logic      modeCmd;
  logic      captureNow;

  chanMode_t modeReg;
  logic      writeHigh;
  logic      readHigh;
  logic      latchOn;

  // Decode of the shared control port.
  always_comb begin
    word       = ctrlWord_t'(ctrlData);
    selHit     = ctrlWe && (word.sel == MY_SEL) && (word.sel != SEL_READBACK);
    latchCmd   = selHit && (word.access == ACC_LATCH);
    modeCmd    = selHit && (word.access == ACC_LOHI) && !word.bcd
                 && modeSupported(word.mode);
    captureNow = latchCmd && !latchOn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= MODE_ONESHOT;
    end else if (modeCmd) begin
      modeReg <= chanMode_t'(word.mode);
    end
  end

  // Write byte pointer.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      writeHigh <= 1'b0;
    end else if (dataWe) begin
      writeHigh <= !writeHigh;
    end
  end

  // Read byte pointer and latch hold.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      readHigh <= 1'b0;
      latchOn  <= 1'b0;
    end else if (captureNow) begin
      readHigh <= 1'b0;
      latchOn  <= 1'b1;
    end else if (dataRe) begin
      readHigh <= !readHigh;
      if (latchOn && readHigh) begin
        latchOn <= 1'b0;
      end
    end
  end

  always_comb begin
    dpStb.wrLow       = dataWe && !writeHigh;
    dpStb.wrHigh      = dataWe && writeHigh;
    dpStb.capture     = captureNow;
    dpStb.periodic    = (modeReg != MODE_ONESHOT);
    dpStb.showLatched = latchOn;
    dpStb.showHigh    = readHigh;
  end

endmodule

// File: rtl/ptmr_datapath.sv
module ptmr_datapath
  import ptmr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  dpStrobe_t         dpStb,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  output logic              timerOut,
  output logic              irqPulse
);

  localparam int CNT_W = 2 * BYTE_W;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] initCount;
  logic [CNT_W-1:0] periodReg;
  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] latchedVal;
  logic             running;
  logic             outHigh;
  logic             irqReg;

  logic [CNT_W-1:0] newCount;
  logic [CNT_W-1:0] newPeriod;
  logic             startOk;
  logic [CNT_W-1:0] liveCount;
  logic             terminal;
  logic [CNT_W-1:0] rdWord;

  always_comb begin
    newCount  = {wrData, initCount[BYTE_W-1:0]};
    startOk   = dpStb.periodic ? (newCount > ONE) : (newCount != '0);
    newPeriod = dpStb.periodic ? (newCount - ONE) : newCount;
    liveCount = running ? (dpStb.periodic ? (remain + ONE) : remain) : '0;
    terminal  = running && tickEn && (remain == ONE)
                && !dpStb.wrLow && !dpStb.wrHigh;
    rdWord    = dpStb.showLatched ? latchedVal : liveCount;
    rdData    = dpStb.showHigh ? rdWord[CNT_W-1:BYTE_W] : rdWord[BYTE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchedVal <= '0;
    end else if (dpStb.capture) begin
      latchedVal <= liveCount;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      initCount <= '0;
      periodReg <= '0;
      remain    <= '0;
      running   <= 1'b0;
      outHigh   <= 1'b0;
      irqReg    <= 1'b0;
    end else begin
      irqReg <= terminal;
      if (dpStb.wrLow) begin
        initCount[BYTE_W-1:0] <= wrData;
        running               <= 1'b0;
        outHigh               <= 1'b0;
      end else if (dpStb.wrHigh) begin
        initCount[CNT_W-1:BYTE_W] <= wrData;
        if (startOk) begin
          periodReg <= newPeriod;
          remain    <= newPeriod;
          running   <= 1'b1;
        end
      end else if (running && tickEn) begin
        if (remain == ONE) begin
          if (dpStb.periodic) begin
            remain <= periodReg;
          end else begin
            remain  <= '0;
            running <= 1'b0;
            outHigh <= 1'b1;
          end
        end else begin
          remain <= remain - ONE;
        end
      end
    end
  end

  assign timerOut = outHigh;
  assign irqPulse = irqReg;

endmodule

// File: rtl/ptmr_channel.sv
module ptmr_channel
  import ptmr_pkg::*;
#(
  parameter int CHAN_ID = 0,
  parameter int BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              ctrlWe,
  input  logic [7:0]        ctrlData,
  input  logic              dataWe,
  input  logic [BYTE_W-1:0] dataWdata,
  input  logic              dataRe,
  output logic [BYTE_W-1:0] dataRdata,
  output logic              timerOut,
  output logic              irqPulse
);

  dpStrobe_t dpStb;

  ptmr_ctrl #(
    .CHAN_ID(CHAN_ID)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .ctrlWe  (ctrlWe),
    .ctrlData(ctrlData),
    .dataWe  (dataWe),
    .dataRe  (dataRe),
    .dpStb   (dpStb)
  );

  ptmr_datapath #(
    .BYTE_W(BYTE_W)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .tickEn  (tickEn),
    .dpStb   (dpStb),
    .wrData  (dataWdata),
    .rdData  (dataRdata),
    .timerOut(timerOut),
    .irqPulse(irqPulse)
  );

endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker
  import ptmr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              dataWe,
  input logic              dataRe,
  input logic [BYTE_W-1:0] dataRdata,
  input logic              timerOut,
  input logic              irqPulse,
  input dpStrobe_t         dpStb
);

  // R1: the byte pointer never targets the same half twice in a row
  assert_low_then_high_R1: assert property (@(posedge clk) disable iff (!rstN)
    dpStb.wrLow |=> !dpStb.wrLow);
  assert_high_then_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    dpStb.wrHigh |=> !dpStb.wrHigh);

  // R2: a low byte write leaves the output low
  assert_low_write_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    dpStb.wrLow |=> !timerOut);

  // R5: interrupt is a single-cycle pulse
  assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);

  // R5: output only rises together with an interrupt
  assert_out_rise_with_irq_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timerOut) |-> irqPulse);

  // R7: a held snapshot stays stable while it is not being read
  assert_latch_frozen_R7: assert property (@(posedge clk) disable iff (!rstN)
    (dpStb.showLatched && !dataRe) |=> (dpStb.showLatched && $stable(dataRdata)));

  // R11: no tick and no reload means no interrupt next cycle
  assert_no_tick_no_irq_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !dataWe) |=> !irqPulse);

endmodule

bind ptmr_channel ptmr_checker #(
  .BYTE_W(BYTE_W)
) i_checker (
  .clk      (clk),
  .rstN     (rstN),
  .tickEn   (tickEn),
  .dataWe   (dataWe),
  .dataRe   (dataRe),
  .dataRdata(dataRdata),
  .timerOut (timerOut),
  .irqPulse (irqPulse),
  .dpStb    (dpStb)
);

// File: tb/test_ptmr_channel.sv
`timescale 1ns/1ps
module test_ptmr_channel;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       ctrlWe = 1'b0;
  logic [7:0] ctrlData = 8'h00;
  logic       dataWe = 1'b0;
  logic [7:0] dataWdata = 8'h00;
  logic       dataRe = 1'b0;
  logic [7:0] dataRdata;
  logic       timerOut;
  logic       irqPulse;

  int checks = 0;
  int errors = 0;
  int irqCount = 0;
  bit done = 1'b0;

  always #2 clk = !clk;

  ptmr_channel #(.CHAN_ID(0), .BYTE_W(8)) i_ptmr_channel (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .ctrlWe(ctrlWe),
    .ctrlData(ctrlData), .dataWe(dataWe), .dataWdata(dataWdata),
    .dataRe(dataRe), .dataRdata(dataRdata), .timerOut(timerOut),
    .irqPulse(irqPulse)
  );

  always @(negedge clk) if (irqPulse) irqCount++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic wrCtrl(input logic [7:0] b);
    @(negedge clk); ctrlWe = 1'b1; ctrlData = b;
    @(negedge clk); ctrlWe = 1'b0;
  endtask

  task automatic wrByte(input logic [7:0] b);
    @(negedge clk); dataWe = 1'b1; dataWdata = b;
    @(negedge clk); dataWe = 1'b0;
  endtask

  task automatic loadCount(input logic [15:0] c);
    wrByte(c[7:0]);
    wrByte(c[15:8]);
  endtask

  task automatic rdByte(output logic [7:0] b);
    @(negedge clk); dataRe = 1'b1; #1 b = dataRdata;
    @(negedge clk); dataRe = 1'b0;
  endtask

  task automatic rdWord(output logic [15:0] w);
    logic [7:0] lo;
    logic [7:0] hi;
    rdByte(lo);
    rdByte(hi);
    w = {hi, lo};
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic testReset();
    logic [15:0] w;
    settle();
    check("R2 reset out", int'(timerOut), 0);
    check("R5 reset irq", int'(irqPulse), 0);
    rdWord(w);
    check("R2 reset live read", int'(w), 0);
  endtask

  task automatic testOneShot();
    logic [15:0] w;
    wrCtrl(8'h30);
    loadCount(16'h0005);
    rdWord(w);
    check("R3 R9 one-shot live", int'(w), 5);
    irqCount = 0;
    ticks(4);
    settle();
    check("R3 no irq before count", irqCount, 0);
    check("R5 out low before tc", int'(timerOut), 0);
    rdWord(w);
    check("R9 one-shot remaining", int'(w), 1);
    ticks(1);
    settle();
    check("R3 R5 irq at tc", irqCount, 1);
    check("R5 out high at tc", int'(timerOut), 1);
    rdWord(w);
    check("R5 stopped live read", int'(w), 0);
    ticks(10);
    settle();
    check("R5 no further irq", irqCount, 1);
    check("R5 out stays high", int'(timerOut), 1);
    wrByte(8'h07);
    settle();
    check("R2 low write clears out", int'(timerOut), 0);
    wrByte(8'h00);
    rdWord(w);
    check("R1 R3 reload live", int'(w), 7);
  endtask

  task automatic testPeriodic();
    logic [15:0] w;
    wrCtrl(8'h34);
    loadCount(16'h0006);
    rdWord(w);
    check("R9 rate live plus one", int'(w), 6);
    irqCount = 0;
    ticks(5);
    settle();
    check("R4 rate first irq", irqCount, 1);
    ticks(15);
    settle();
    check("R4 rate irq count", irqCount, 4);
    check("R4 rate out low", int'(timerOut), 0);
    rdWord(w);
    check("R4 rate reloaded", int'(w), 6);
    wrCtrl(8'h36);
    loadCount(16'h0003);
    irqCount = 0;
    ticks(10);
    settle();
    check("R4 wave irq count", irqCount, 5);
    rdWord(w);
    check("R9 wave live", int'(w), 3);
  endtask

  task automatic testHalt();
    logic [15:0] w;
    wrCtrl(8'h34);
    loadCount(16'h0004);
    irqCount = 0;
    @(negedge clk); tickEn = 1'b0;
    repeat (20) @(negedge clk);
    settle();
    check("R11 no tick no irq", irqCount, 0);
    rdWord(w);
    check("R11 count holds", int'(w), 4);
    wrByte(8'h09);
    rdWord(w);
    check("R2 halted live read", int'(w), 0);
    ticks(10);
    settle();
    check("R2 halted no irq", irqCount, 0);
    wrByte(8'h00);
    rdWord(w);
    check("R1 high completes", int'(w), 9);
  endtask

  task automatic testNoStart();
    logic [15:0] w;
    wrCtrl(8'h30);
    loadCount(16'h0000);
    irqCount = 0;
    ticks(5);
    settle();
    rdWord(w);
    check("R6 zero one-shot idle", int'(w), 0);
    check("R6 zero one-shot no irq", irqCount, 0);
    wrCtrl(8'h34);
    loadCount(16'h0001);
    ticks(5);
    settle();
    rdWord(w);
    check("R6 one periodic idle", int'(w), 0);
    check("R6 one periodic no irq", irqCount, 0);
  endtask

  task automatic testLatch();
    logic [15:0] w;
    logic [7:0]  b;
    wrCtrl(8'h34);
    loadCount(16'h0305);
    ticks(3);
    wrCtrl(8'h00);
    ticks(5);
    wrCtrl(8'h00);
    rdWord(w);
    check("R7 latched value", int'(w), 16'h0302);
    rdWord(w);
    check("R7 released live", int'(w), 16'h02FD);
    wrCtrl(8'h30);
    loadCount(16'h1234);
    rdByte(b);
    check("R9 live low byte", int'(b), 8'h34);
    wrCtrl(8'h00);
    rdWord(w);
    check("R8 pointer reset by latch", int'(w), 16'h1234);
  endtask

  task automatic testDecode();
    logic [15:0] w;
    wrCtrl(8'h34);
    loadCount(16'h000A);
    wrCtrl(8'h70);
    wrCtrl(8'hF0);
    wrCtrl(8'h31);
    wrCtrl(8'h10);
    wrCtrl(8'h20);
    wrCtrl(8'h38);
    rdWord(w);
    check("R10 ignored words keep mode", int'(w), 10);
    wrCtrl(8'h40);
    ticks(2);
    rdWord(w);
    check("R10 foreign latch ignored", int'(w), 8);
    wrCtrl(8'h30);
    rdWord(w);
    check("R10 valid word applies", int'(w), 7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testOneShot();
    testPeriodic();
    testHalt();
    testNoStart();
    testLatch();
    testDecode();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule